// File: doc/BRIEF.md
# Frame Transmit Launch Sequencer

This block starts the transmission of a frame whose payload is already loaded into a radio transceiver's transmit buffer. A single `go` strobe runs a fixed series of register accesses through a command port to a separate register-access engine. The engine acknowledges each access with `acc_done`. The series works as follows:

1. Fetch the upper control byte of the frame-control register.
2. Write back a 16-bit word that keeps those control bits and inserts the new frame length.
3. For a delayed send only, program the 40-bit launch time.
4. Force the transceiver idle.
5. Issue the transmit start.
6. Turn the receiver back on.

The payload length, the delayed-send flag and the launch time are captured when `go` is accepted. The caller may change them afterwards. Register identifiers are parameters: frame control is 0x08, delayed-send time is 0x0A and system control is 0x0D. Each access carries a register identifier, a 15-bit sub-address, a byte count and up to 40 bits of write data, least significant byte first. Completion is reported by a single-cycle `done` pulse. A `go` that arrives while a sequence is running is dropped, and it sets a sticky error flag.

Top module: `lsq_tx_launch`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `cmd_valid` are all 0.
- R2: When `go` is sampled high while `busy` is 0, `cmd_valid` is first seen high after the second following rising edge. The first command is a 1-byte read (`cmd_write`=0) of register 0x08 at sub-address 1.
- R3: Each command is a one-cycle `cmd_valid` strobe. The next command's strobe is seen after the second rising edge that follows the edge sampling `acc_done`.
- R4: The frame length is the payload length plus 2. A payload length of 125 or more is first replaced by 125, so the frame length never exceeds 127.
- R5: The second command is a 2-byte write to register 0x08, sub-address 0. Data bits 15:10 are bits 7:2 of the byte returned by the first read, and bits 9:0 are the frame length.
- R6: With `delayed`=1, a 5-byte write of `launch_time` to register 0x0A, sub-address 0, follows the length write. With `delayed`=0 this write is absent.
- R7: Before the start command, a 1-byte write of 0x40 goes to register 0x0D, sub-address 0.
- R8: The start command is a 1-byte write to register 0x0D, sub-address 0, of 0x02. It is 0x06 when `delayed`=1.
- R9: The last command is a 1-byte write of 0x01 to register 0x0D, sub-address 1.
- R10: `done` pulses high for exactly one cycle after the edge that samples the final `acc_done`. `busy` falls on that same edge, and `done` is 0 at all other times.
- R11: A `go` sampled while `busy` is 1 leaves the command series of the running sequence unchanged. It sets `err`, which stays 1 until reset.
- R12: A `go` sampled in the cycle in which `done` is high is accepted and starts a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start strobe |
| pay_len | input | 10 | Payload length in bytes |
| delayed | input | 1 | Request a timed launch |
| launch_time | input | 40 | Launch time for a timed launch |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Sticky flag: start requested while busy |
| cmd_valid | output | 1 | Command strobe to the access engine |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_reg | output | 6 | Register identifier |
| cmd_sub | output | 15 | Sub-address |
| cmd_nbytes | output | 3 | Bytes to transfer |
| cmd_wdata | output | 40 | Write data, LSB first |
| acc_done | input | 1 | Access completion from the engine |
| acc_rdata | input | 8 | Byte returned by a read |

## Verification
Two pairs of events can share a cycle. In the first, a new `go` lands in the same cycle as the `acc_done` that ends a step. The bench drives `go` together with the third access's completion, using different length and mode inputs. It judges the result by the unchanged remainder of the command series and by `err` reading 1. In the second, a `go` lands in the cycle of the `done` pulse. The bench drives it there and expects a full new series to begin at the normal two-edge latency. A near-exhaustive sweep over every payload length, with mixed modes and access latencies, checks each command against values the bench computes itself.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  localparam int ACC_DW = 40;
  localparam int REG_W  = 6;
  localparam int SUB_W  = 15;
  localparam int NB_W   = 3;

  typedef enum logic [2:0] {
    STP_RDCTL  = 3'd0,
    STP_WRLEN  = 3'd1,
    STP_WRTIME = 3'd2,
    STP_HALT   = 3'd3,
    STP_START  = 3'd4,
    STP_RXON   = 3'd5
  } step_e;

  typedef struct packed {
    logic              wr;
    logic [REG_W-1:0]  reg_id;
    logic [SUB_W-1:0]  sub;
    logic [NB_W-1:0]   nbytes;
    logic [ACC_DW-1:0] data;
  } acc_cmd_t;
endpackage

// File: rtl/lsq_len_fmt.sv
module lsq_len_fmt #(
  parameter int LEN_W = 10,
  parameter int FL_W  = 10,
  parameter int CW    = 16,
  parameter int CLIP  = 125,
  parameter int CRC   = 2
) (
  input  logic [LEN_W-1:0] pay,
  input  logic [7:0]       ctl_byte,
  output logic [CW-1:0]    word
);
  localparam int HI_W = CW - FL_W;

  logic [FL_W-1:0] clipped;
  logic [FL_W-1:0] flen;

  // limit the payload, then account for the checksum bytes
  always_comb begin
    if (pay >= LEN_W'(CLIP)) clipped = FL_W'(CLIP);
    else                     clipped = FL_W'(pay);
    flen = clipped + FL_W'(CRC);
    word = {ctl_byte[7 -: HI_W], flen};
  end
endmodule

// File: rtl/lsq_cmd_sel.sv
module lsq_cmd_sel
  import lsq_pkg::*;
#(
  parameter int          CW         = 16,
  parameter logic [5:0]  REG_FCTL   = 6'h08,
  parameter logic [5:0]  REG_DLY    = 6'h0A,
  parameter logic [5:0]  REG_SCTL   = 6'h0D,
  parameter logic [7:0]  HALT_CODE  = 8'h40,
  parameter logic [7:0]  START_CODE = 8'h02,
  parameter logic [7:0]  DLY_BIT    = 8'h04,
  parameter logic [7:0]  RXON_CODE  = 8'h01
) (
  input  step_e              step,
  input  logic               delayed,
  input  logic [CW-1:0]      len_word,
  input  logic [ACC_DW-1:0]  launch,
  output acc_cmd_t           cmd
);
  always_comb begin
    cmd = '0;
    unique case (step)
      STP_RDCTL: begin
        cmd.wr = 1'b0; cmd.reg_id = REG_FCTL; cmd.sub = SUB_W'(1); cmd.nbytes = NB_W'(1);
      end
      STP_WRLEN: begin
        cmd.wr = 1'b1; cmd.reg_id = REG_FCTL; cmd.sub = '0; cmd.nbytes = NB_W'(CW / 8);
        cmd.data = ACC_DW'(len_word);
      end
      STP_WRTIME: begin
        cmd.wr = 1'b1; cmd.reg_id = REG_DLY; cmd.sub = '0; cmd.nbytes = NB_W'(ACC_DW / 8);
        cmd.data = launch;
      end
      STP_HALT: begin
        cmd.wr = 1'b1; cmd.reg_id = REG_SCTL; cmd.sub = '0; cmd.nbytes = NB_W'(1);
        cmd.data = ACC_DW'(HALT_CODE);
      end
      STP_START: begin
        cmd.wr = 1'b1; cmd.reg_id = REG_SCTL; cmd.sub = '0; cmd.nbytes = NB_W'(1);
        cmd.data = ACC_DW'(delayed ? (START_CODE | DLY_BIT) : START_CODE);
      end
      STP_RXON: begin
        cmd.wr = 1'b1; cmd.reg_id = REG_SCTL; cmd.sub = SUB_W'(1); cmd.nbytes = NB_W'(1);
        cmd.data = ACC_DW'(RXON_CODE);
      end
      default: cmd = '0;
    endcase
  end
endmodule

// File: rtl/lsq_ctrl.sv
module lsq_ctrl
  import lsq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  go,
  input  logic  delayed_q,
  input  logic  acc_done,
  output step_e step,
  output logic  issue,
  output logic  accept,
  output logic  rd_cap,
  output logic  busy,
  output logic  done,
  output logic  err
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_e;
  st_e st;

  function automatic step_e next_step(step_e s, logic dly);
    case (s)
      STP_RDCTL:  next_step = STP_WRLEN;
      STP_WRLEN:  next_step = dly ? STP_WRTIME : STP_HALT;
      STP_WRTIME: next_step = STP_HALT;
      STP_HALT:   next_step = STP_START;
      default:    next_step = STP_RXON;
    endcase
  endfunction

  assign issue  = (st == S_ISSUE);
  assign accept = go && !busy;
  assign rd_cap = (st == S_WAIT) && acc_done && (step == STP_RDCTL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      step <= STP_RDCTL;
      busy <= 1'b0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && busy) err <= 1'b1;
      case (st)
        S_IDLE: if (go) begin
          st   <= S_ISSUE;
          step <= STP_RDCTL;
          busy <= 1'b1;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (acc_done) begin
          if (step == STP_RXON) begin
            st   <= S_IDLE;
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            step <= next_step(step, delayed_q);
            st   <= S_ISSUE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst) err |=> err);
  a_r7_halt_before_start: assert property (@(posedge clk) disable iff (rst)
    (issue && step == STP_START) |-> $past(step) == STP_HALT);
endmodule

// File: rtl/lsq_tx_launch.sv
module lsq_tx_launch
  import lsq_pkg::*;
#(
  parameter int          LEN_W    = 10,
  parameter int          FL_W     = 10,
  parameter int          CLIP     = 125,
  parameter int          CRC      = 2,
  parameter logic [5:0]  REG_FCTL = 6'h08,
  parameter logic [5:0]  REG_DLY  = 6'h0A,
  parameter logic [5:0]  REG_SCTL = 6'h0D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [LEN_W-1:0]  pay_len,
  input  logic              delayed,
  input  logic [39:0]       launch_time,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              cmd_valid,
  output logic              cmd_write,
  output logic [5:0]        cmd_reg,
  output logic [14:0]       cmd_sub,
  output logic [2:0]        cmd_nbytes,
  output logic [39:0]       cmd_wdata,
  input  logic              acc_done,
  input  logic [7:0]        acc_rdata
);
  localparam int CW  = 16;
  localparam int LIM = CLIP + CRC;

  logic [LEN_W-1:0]  pay_q;
  logic              dly_q;
  logic [ACC_DW-1:0] time_q;
  logic [7:0]        ctl_q;
  logic [CW-1:0]     len_word;
  step_e             step;
  logic              issue, accept, rd_cap;
  acc_cmd_t          sel_cmd, cmd_q;

  lsq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .go(go), .delayed_q(dly_q), .acc_done(acc_done),
    .step(step), .issue(issue), .accept(accept), .rd_cap(rd_cap),
    .busy(busy), .done(done), .err(err)
  );

  lsq_len_fmt #(.LEN_W(LEN_W), .FL_W(FL_W), .CW(CW), .CLIP(CLIP), .CRC(CRC)) u_fmt (
    .pay(pay_q), .ctl_byte(ctl_q), .word(len_word)
  );

  lsq_cmd_sel #(.CW(CW), .REG_FCTL(REG_FCTL), .REG_DLY(REG_DLY), .REG_SCTL(REG_SCTL)) u_sel (
    .step(step), .delayed(dly_q), .len_word(len_word), .launch(time_q), .cmd(sel_cmd)
  );

  // request capture and read-back byte
  always_ff @(posedge clk) begin
    if (rst) begin
      pay_q  <= '0;
      dly_q  <= 1'b0;
      time_q <= '0;
      ctl_q  <= '0;
    end else begin
      if (accept) begin
        pay_q  <= pay_len;
        dly_q  <= delayed;
        time_q <= launch_time;
      end
      if (rd_cap) ctl_q <= acc_rdata;
    end
  end

  // registered command port
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_q     <= '0;
    end else begin
      cmd_valid <= issue;
      if (issue) cmd_q <= sel_cmd;
    end
  end

  assign cmd_write  = cmd_q.wr;
  assign cmd_reg    = cmd_q.reg_id;
  assign cmd_sub    = cmd_q.sub;
  assign cmd_nbytes = cmd_q.nbytes;
  assign cmd_wdata  = cmd_q.data;

  a_r3_valid_in_busy: assert property (@(posedge clk) disable iff (rst) cmd_valid |-> busy);
  a_r3_valid_single: assert property (@(posedge clk) disable iff (rst) cmd_valid |=> !cmd_valid);
  a_r4_len_bound: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_write && cmd_reg == REG_FCTL)
      |-> (cmd_wdata[FL_W-1:0] <= FL_W'(LIM)) && (cmd_wdata[FL_W-1:0] >= FL_W'(CRC)));
endmodule

// File: tb/sim_lsq_tx_launch.sv
`timescale 1ns/1ps
module sim_lsq_tx_launch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        go = 1'b0;
  logic [9:0]  pay_len = '0;
  logic        delayed = 1'b0;
  logic [39:0] launch_time = '0;
  logic        busy, done, err, cmd_valid, cmd_write;
  logic [5:0]  cmd_reg;
  logic [14:0] cmd_sub;
  logic [2:0]  cmd_nbytes;
  logic [39:0] cmd_wdata;
  logic        acc_done = 1'b0;
  logic [7:0]  acc_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit fin = 1'b0;

  always #2 clk = ~clk;

  lsq_tx_launch u0 (
    .clk(clk), .rst(rst), .go(go), .pay_len(pay_len), .delayed(delayed),
    .launch_time(launch_time), .busy(busy), .done(done), .err(err),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_reg(cmd_reg), .cmd_sub(cmd_sub),
    .cmd_nbytes(cmd_nbytes), .cmd_wdata(cmd_wdata), .acc_done(acc_done), .acc_rdata(acc_rdata)
  );

  task automatic chk(bit ok, string tag, logic [64:0] act, logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected command k: {write, reg, sub, nbytes, data}
  function automatic logic [64:0] exp_cmd(int k, int pay, bit dly, logic [39:0] tm, logic [7:0] ctl);
    int idx = (!dly && k >= 2) ? k + 1 : k;
    int fl  = (pay >= 125) ? 127 : pay + 2;
    case (idx)
      0: exp_cmd = {1'b0, 6'h08, 15'd1, 3'd1, 40'd0};
      1: exp_cmd = {1'b1, 6'h08, 15'd0, 3'd2, 24'd0, ctl[7:2], 10'(fl)};
      2: exp_cmd = {1'b1, 6'h0A, 15'd0, 3'd5, tm};
      3: exp_cmd = {1'b1, 6'h0D, 15'd0, 3'd1, 40'h40};
      4: exp_cmd = {1'b1, 6'h0D, 15'd0, 3'd1, dly ? 40'h06 : 40'h02};
      default: exp_cmd = {1'b1, 6'h0D, 15'd1, 3'd1, 40'h01};
    endcase
  endfunction

  function automatic string tag_of(int k, bit dly);
    int idx = (!dly && k >= 2) ? k + 1 : k;
    case (idx)
      0: tag_of = "R2 first read";
      1: tag_of = "R5 length write";
      2: tag_of = "R6 launch time";
      3: tag_of = "R7 halt";
      4: tag_of = "R8 start";
      default: tag_of = "R9 rx re-enable";
    endcase
  endfunction

  // caller is at a negedge
  task automatic launch(int pay, bit dly, logic [39:0] tm);
    go = 1'b1; pay_len = 10'(pay); delayed = dly; launch_time = tm;
  endtask

  // serves one sequence whose go was driven at the current negedge
  task automatic serve(int pay, bit dly, logic [39:0] tm, int lat, logic [7:0] ctl, bit busy_go);
    int ncmd = dly ? 6 : 5;
    for (int k = 0; k < ncmd; k++) begin
      int n = 0;
      logic [64:0] act, exp;
      do begin
        @(negedge clk);
        go = 1'b0; acc_done = 1'b0; n++;
      end while (!cmd_valid && n < 40);
      chk(n == 2, (k == 0) ? "R2 start latency" : "R3 step latency", 65'(n), 65'd2);
      chk(!done, "R10 no early done", 65'(done), 65'd0);
      exp = exp_cmd(k, pay, dly, tm, ctl);
      act = {cmd_write, cmd_reg, cmd_sub, cmd_nbytes, cmd_wdata};
      if (k == 0) act[39:0] = '0;
      chk(act == exp, tag_of(k, dly), act, exp);
      if (k == 1)
        chk(cmd_wdata[9:0] == exp[9:0], "R4 frame length", 65'(cmd_wdata[9:0]), 65'(exp[9:0]));
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        if (i == 0) chk(!cmd_valid, "R3 single strobe", 65'(cmd_valid), 65'd0);
      end
      acc_done = 1'b1;
      acc_rdata = ctl;
      if (busy_go && k == 2) begin
        go = 1'b1; pay_len = 10'd3; delayed = !dly; launch_time = '0;
      end
    end
    @(negedge clk);
    acc_done = 1'b0; go = 1'b0;
    chk(done && !busy, "R10 done pulse", {63'd0, done, busy}, 65'b10);
    if (busy_go) chk(err, "R11 err set", 65'(err), 65'd1);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; go = 1'b0; acc_done = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, err, cmd_valid} == 4'b0, "R1 reset state", 65'({busy, done, err, cmd_valid}), 65'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // sweep every payload length, mixed modes and latencies
    for (int p = 0; p < 1024; p++) begin
      bit d = p[0] ^ p[5];
      logic [39:0] tm = {p[9:0], 30'h1234_5678 ^ 30'(p * 977)};
      logic [7:0] c = 8'(p * 37 + 11);
      @(negedge clk);
      launch(p, d, tm);
      serve(p, d, tm, 1 + (p % 3), c, 1'b0);
    end
    @(negedge clk);
    chk(!err, "R11 no err without overlap", 65'(err), 65'd0);
    // clip boundary, both modes
    for (int p = 124; p <= 126; p++) begin
      for (int d = 0; d < 2; d++) begin
        @(negedge clk);
        launch(p, d[0], 40'hAB_CDEF_0123);
        serve(p, d[0], 40'hAB_CDEF_0123, 2, 8'hFF, 1'b0);
      end
    end
    // go in the done cycle is accepted (R12)
    @(negedge clk);
    launch(40, 1'b1, 40'h11_2233_4455);
    serve(40, 1'b1, 40'h11_2233_4455, 1, 8'h5C, 1'b0);
    launch(200, 1'b0, 40'h0);
    serve(200, 1'b0, 40'h0, 3, 8'hA3, 1'b0);
    // go coinciding with a step completion while busy (R11)
    @(negedge clk);
    launch(60, 1'b1, 40'hFE_DCBA_9876);
    serve(60, 1'b1, 40'hFE_DCBA_9876, 2, 8'h96, 1'b1);
    @(negedge clk);
    launch(10, 1'b0, 40'h0);
    serve(10, 1'b0, 40'h0, 1, 8'h04, 1'b1);
    repeat (3) @(negedge clk);
    chk(err, "R11 err sticky", 65'(err), 65'd1);
    do_reset();
    fin = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule